// File: doc/BRIEF.md
# Two-Level Ten-Source Interrupt Arbiter

This block sits between ten interrupt sources and a microcontroller core. Six sources are classic: two external request flags, three timer overflow flags and a serial port that raises one request for either its transmit-done or its receive-done flag. The flag registers for these six live outside the block. The other four are extra external pins. The block owns their flags and sets each one on a single detected transition. Two of these pins fire on a rising edge and two on a falling edge.

Each source has an individual enable and a high/low priority bit, and one global enable masks all of them. The arbiter chooses the highest level first and the lowest source index within that level. It presents the winner to the core as a registered request plus an 8-bit vector address. When the core acknowledges, the block records the level now in service. When the core signals a return, it drops the most recent level. This record decides whether a new request may preempt the routine that is running.

The four extra pins also drive an asynchronous wake line. That line rises on an enabled active edge with no clock edge needed, so a core whose clocks are stopped can still resume.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o, svc_hi_o, svc_lo_o and xflag_o are all 0.
- R2: Source index i (0 = ext0, 1 = tmr0, 2 = ext1, 3 = tmr1, 4 = serial, 5 = tmr2, 6..9 = xint_pin[0..3]) gets vector 8*i+3 for i below 6, and 8*i+0x13 for i of 6 or more. This gives 03h,0Bh,13h,1Bh,23h,2Bh,43h,4Bh,53h,5Bh.
- R3: Among enabled pending sources, any high-priority source beats every low-priority source. Within one level the lowest index wins. irq_hi_o reports the winner's level.
- R4: A source takes part only when its enable bit is 1 (cls_en[i] for i<6, ext_en[i-6] otherwise) and glb_en is 1. With glb_en at 0, irq_o stays 0.
- R5: The serial source (index 4) is pending when ser_tx_done or ser_rx_done is 1.
- R6: xint_pin[0] and xint_pin[2] set their flags (xflag_o bits 0 and 2) on a rising edge. xint_pin[1] and xint_pin[3] set bits 1 and 3 on a falling edge. A transition in the other direction sets nothing.
- R7: An extra-pin flag is cleared by a 1 on its xflag_clr bit, or by an acknowledge while that source is the presented winner.
- R8: While svc_hi_o is 1, irq_o stays 0. While only svc_lo_o is 1, irq_o rises only for a high-priority winner. Low requests and same-level requests never preempt.
- R9: An acknowledge while irq_o is 1 sets svc_hi_o or svc_lo_o per irq_hi_o. A return clears svc_hi_o if it is set, and otherwise clears svc_lo_o.
- R10: wake_o rises combinationally, before any clock edge, when an enabled extra pin makes its active transition.
- R11: irq_o and vec_o are registered. They reflect a pending request from the first clock edge after it appears. irq_o is 0 in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_req | input | 1 | Classic external request flag 0 |
| tmr0_req | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | Classic external request flag 1 |
| tmr1_req | input | 1 | Timer 1 overflow flag |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| tmr2_req | input | 1 | Timer 2 flag |
| xint_pin | input | 4 | Raw asynchronous extra external pins |
| glb_en | input | 1 | Global enable (bit 7 of the main enable register) |
| cls_en | input | 6 | Enables of sources 0..5 (bits 0..5 of the main enable register) |
| cls_pri | input | 6 | Priority bits of sources 0..5, 1 = high |
| ext_en | input | 4 | Enables of sources 6..9 |
| ext_pri | input | 4 | Priority bits of sources 6..9, 1 = high |
| xflag_clr | input | 4 | Software clear pulses for the extra-pin flags |
| ack_i | input | 1 | Core acknowledge of the presented vector |
| ret_i | input | 1 | Core return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the core |
| irq_hi_o | output | 1 | Level of the presented request, 1 = high |
| vec_o | output | 8 | Vector address of the presented request |
| xflag_o | output | 4 | Extra-pin flags (bits 4..7 of the extended flag register) |
| svc_hi_o | output | 1 | A high-level routine is in service |
| svc_lo_o | output | 1 | A low-level routine is in service |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The bench checks level-before-order arbitration with random flag, enable and priority mixes. An arbiter that scanned natural order first would hand a low-priority timer the vector ahead of a high-priority extra pin. It drives each extra pin in both directions, because a swapped polarity would latch on release instead of assertion. Nesting is exercised as low, then high, then a blocked high, then returns. A stack that popped the wrong level, or that let equal levels preempt, shows up as a wrong irq_o after the first return. The wake line is sampled between clock edges, which exposes any version that registers it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NCLASSIC = 6;
  localparam int XNUM     = 4;
  localparam int NSRC     = NCLASSIC + XNUM;
  localparam int IDW      = $clog2(NSRC);

  // Classic block starts at 03h, extra block at 43h, 8 bytes per slot.
  function automatic logic [7:0] vec_of(input logic [IDW-1:0] idx);
    logic [7:0] base;
    base = {{(8-IDW){1'b0}}, idx} << 3;
    if (idx < IDW'(NCLASSIC)) vec_of = base + 8'h03;
    else                      vec_of = base + 8'h13;
  endfunction
endpackage

// File: rtl/irqc_edge_cap.sv
module irqc_edge_cap #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_o,
  output logic wake_o
);
  localparam logic IDLE = ~RISE;

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;
  logic              cur;

  assign cur = sh_q[STAGES-1];

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin};
    prev_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = cur & ~prev_q;
      assign wake_o = pin & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~cur & prev_q;
      assign wake_o = ~pin & prev_q;
    end
  endgenerate
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] active,
  input  logic [NSRC-1:0] pri,
  input  logic            svc_hi,
  input  logic            svc_lo,
  output logic            grant,
  output logic            grant_hi,
  output logic [IDW-1:0]  grant_idx
);
  logic [NSRC-1:0] hi_set, lo_set;
  logic            hi_any, lo_any;
  logic [IDW-1:0]  hi_idx, lo_idx;

  assign hi_set = active & pri;
  assign lo_set = active & ~pri;

  always_comb begin
    hi_any = 1'b0;
    hi_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_set[i]) begin
        hi_any = 1'b1;
        hi_idx = IDW'(i);
      end
    end
  end

  always_comb begin
    lo_any = 1'b0;
    lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (lo_set[i]) begin
        lo_any = 1'b1;
        lo_idx = IDW'(i);
      end
    end
  end

  always_comb begin
    grant     = 1'b0;
    grant_hi  = 1'b0;
    grant_idx = '0;
    if (hi_any) begin
      grant     = ~svc_hi;
      grant_hi  = 1'b1;
      grant_idx = hi_idx;
    end else if (lo_any) begin
      grant     = ~svc_hi & ~svc_lo;
      grant_idx = lo_idx;
    end
  end
endmodule

// File: rtl/irqc_svc.sv
module irqc_svc (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic svc_hi,
  output logic svc_lo
);
  logic hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (pop) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (push) begin
      if (push_hi) hi_d = 1'b1;
      else         lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign svc_hi = hi_q;
  assign svc_lo = lo_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext0_req,
  input  logic            tmr0_req,
  input  logic            ext1_req,
  input  logic            tmr1_req,
  input  logic            ser_tx_done,
  input  logic            ser_rx_done,
  input  logic            tmr2_req,
  input  logic [XNUM-1:0] xint_pin,
  input  logic            glb_en,
  input  logic [5:0]      cls_en,
  input  logic [5:0]      cls_pri,
  input  logic [XNUM-1:0] ext_en,
  input  logic [XNUM-1:0] ext_pri,
  input  logic [XNUM-1:0] xflag_clr,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            irq_o,
  output logic            irq_hi_o,
  output logic [7:0]      vec_o,
  output logic [XNUM-1:0] xflag_o,
  output logic            svc_hi_o,
  output logic            svc_lo_o,
  output logic            wake_o
);
  logic [XNUM-1:0] x_edge, x_wake;
  logic [XNUM-1:0] xflag_q, xflag_d, ack_clr;
  logic [NSRC-1:0] pend, enab, active, pri_all;
  logic            grant, grant_hi;
  logic [IDW-1:0]  grant_idx;
  logic            irq_q, irq_d, lvl_q, lvl_d;
  logic [IDW-1:0]  idx_q, idx_d;
  logic            ack_ok;
  logic            svc_hi, svc_lo;

  // Even extra pins trigger on rising edges, odd ones on falling edges.
  generate
    for (genvar k = 0; k < XNUM; k++) begin : g_xin
      irqc_edge_cap #(
        .STAGES (SYNC_STAGES),
        .RISE   ((k % 2) == 0)
      ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (xint_pin[k]),
        .edge_o (x_edge[k]),
        .wake_o (x_wake[k])
      );
      assign ack_clr[k] = ack_ok && (idx_q == IDW'(NCLASSIC + k));
    end
  endgenerate

  assign ack_ok = ack_i & irq_q;

  // A new edge wins over a clear in the same cycle.
  always_comb begin
    xflag_d = (xflag_q & ~(xflag_clr | ack_clr)) | x_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xflag_q <= '0;
    else        xflag_q <= xflag_d;
  end

  assign pend    = {xflag_q, tmr2_req, ser_tx_done | ser_rx_done,
                    tmr1_req, ext1_req, tmr0_req, ext0_req};
  assign enab    = {ext_en, cls_en} & {NSRC{glb_en}};
  assign active  = pend & enab;
  assign pri_all = {ext_pri, cls_pri};

  irqc_pick u_pick (
    .active    (active),
    .pri       (pri_all),
    .svc_hi    (svc_hi),
    .svc_lo    (svc_lo),
    .grant     (grant),
    .grant_hi  (grant_hi),
    .grant_idx (grant_idx)
  );

  irqc_svc u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ack_ok),
    .push_hi (lvl_q),
    .pop     (ret_i),
    .svc_hi  (svc_hi),
    .svc_lo  (svc_lo)
  );

  always_comb begin
    irq_d = grant & ~ack_ok;
    lvl_d = grant_hi;
    idx_d = grant_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      lvl_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= irq_d;
      lvl_q <= lvl_d;
      idx_q <= idx_d;
    end
  end

  assign irq_o    = irq_q;
  assign irq_hi_o = lvl_q;
  assign vec_o    = vec_of(idx_q);
  assign xflag_o  = xflag_q;
  assign svc_hi_o = svc_hi;
  assign svc_lo_o = svc_lo;
  assign wake_o   = |(x_wake & ext_en);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       ack_i,
  input logic       irq_o,
  input logic       irq_hi_o,
  input logic [7:0] vec_o,
  input logic       svc_hi_o,
  input logic       svc_lo_o
);
  // R8
  hi_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi_o |-> !irq_o);

  // R8
  lo_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_lo_o && irq_o) |-> irq_hi_o);

  // R11
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !irq_o);

  // R9
  push_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && irq_hi_o) |=> svc_hi_o);

  // R9
  push_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !irq_hi_o) |=> svc_lo_o);

  // R4
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq_o);

  // R2
  vector_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[2:0] == 3'b011));
endmodule

bind prio_irq_ctrl irqc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glb_en   (glb_en),
  .ack_i    (ack_i),
  .irq_o    (irq_o),
  .irq_hi_o (irq_hi_o),
  .vec_o    (vec_o),
  .svc_hi_o (svc_hi_o),
  .svc_lo_o (svc_lo_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext0_req, tmr0_req, ext1_req, tmr1_req;
  logic       ser_tx_done, ser_rx_done, tmr2_req;
  logic [3:0] xint_pin;
  logic       glb_en;
  logic [5:0] cls_en, cls_pri;
  logic [3:0] ext_en, ext_pri, xflag_clr;
  logic       ack_i, ret_i;
  logic       irq_o, irq_hi_o, svc_hi_o, svc_lo_o, wake_o;
  logic [7:0] vec_o;
  logic [3:0] xflag_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .ext0_req(ext0_req), .tmr0_req(tmr0_req), .ext1_req(ext1_req),
    .tmr1_req(tmr1_req), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
    .tmr2_req(tmr2_req), .xint_pin(xint_pin), .glb_en(glb_en),
    .cls_en(cls_en), .cls_pri(cls_pri), .ext_en(ext_en), .ext_pri(ext_pri),
    .xflag_clr(xflag_clr), .ack_i(ack_i), .ret_i(ret_i),
    .irq_o(irq_o), .irq_hi_o(irq_hi_o), .vec_o(vec_o), .xflag_o(xflag_o),
    .svc_hi_o(svc_hi_o), .svc_lo_o(svc_lo_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Returns {irq, hi, vec} for the classic sources with an empty service record.
  function automatic logic [9:0] model(input logic [5:0] f, input logic g,
                                       input logic [5:0] en, input logic [5:0] pr);
    logic [5:0] act;
    act = f & en & {6{g}};
    for (int i = 0; i < 6; i++)
      if (act[i] && pr[i]) return {1'b1, 1'b1, 8'(8 * i + 3)};
    for (int i = 0; i < 6; i++)
      if (act[i] && !pr[i]) return {1'b1, 1'b0, 8'(8 * i + 3)};
    return 10'd0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; cyc(1); ack_i = 1'b0;
  endtask

  task automatic pulse_ret();
    ret_i = 1'b1; cyc(1); ret_i = 1'b0;
  endtask

  task automatic quiet();
    {ext0_req, tmr0_req, ext1_req, tmr1_req} = '0;
    {ser_tx_done, ser_rx_done, tmr2_req} = '0;
    xflag_clr = 4'hF; cyc(1); xflag_clr = 4'h0;
    cyc(1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog run did not finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] e;
    logic [5:0] f;
    void'($urandom(32'h1d2c));
    rst_n = 1'b0;
    {ext0_req, tmr0_req, ext1_req, tmr1_req} = '0;
    {ser_tx_done, ser_rx_done, tmr2_req} = '0;
    xint_pin = 4'b1010;
    glb_en = 1'b0; cls_en = '0; cls_pri = '0; ext_en = '0; ext_pri = '0;
    xflag_clr = '0; ack_i = 1'b0; ret_i = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    chk("R1 irq", irq_o, 0);
    chk("R1 svc", {svc_hi_o, svc_lo_o}, 0);
    chk("R1 xflag", xflag_o, 0);

    // R11 latency: visible from the first edge after the flag appears
    glb_en = 1'b1; cls_en = 6'h3F; tmr0_req = 1'b1;
    #1 chk("R11 not yet", irq_o, 0);
    cyc(1);
    chk("R11 irq", irq_o, 1);
    chk("R2 tmr0 vec", vec_o, 8'h0B);
    quiet();

    // R3 R4 random classic mixes
    for (int t = 0; t < 300; t++) begin
      f = 6'($urandom);
      {ext0_req, tmr0_req, ext1_req, tmr1_req} = {f[3], f[2], f[1], f[0]};
      ext0_req = f[0]; tmr0_req = f[1]; ext1_req = f[2]; tmr1_req = f[3];
      tmr2_req = f[5];
      ser_tx_done = f[4] & $urandom_range(0, 1);
      ser_rx_done = f[4] & ~ser_tx_done;
      glb_en  = ($urandom_range(0, 7) != 0);
      cls_en  = 6'($urandom);
      cls_pri = 6'($urandom);
      cyc(2);
      e = model(f, glb_en, cls_en, cls_pri);
      chk("R3 R4 R5 irq", irq_o, e[9]);
      if (e[9]) begin
        chk("R3 level", irq_hi_o, e[8]);
        chk("R2 R3 vec", vec_o, e[7:0]);
      end
    end
    quiet();

    // R5 serial: each done flag alone
    glb_en = 1'b1; cls_en = 6'h10; cls_pri = 0;
    ser_rx_done = 1'b1; cyc(2);
    chk("R5 rx vec", {irq_o, vec_o}, {1'b1, 8'h23});
    ser_rx_done = 1'b0; ser_tx_done = 1'b1; cyc(2);
    chk("R5 tx vec", {irq_o, vec_o}, {1'b1, 8'h23});
    quiet();

    // R6 extra pins and R2 extra vectors
    cls_en = 0; ext_en = 4'hF; ext_pri = 0;
    xint_pin[0] = 1'b1; cyc(5);
    chk("R6 rise sets", xflag_o, 4'b0001);
    chk("R2 xint0 vec", {irq_o, vec_o}, {1'b1, 8'h43});
    xint_pin[0] = 1'b0; xflag_clr = 4'b0001; cyc(1); xflag_clr = 0; cyc(5);
    chk("R6 R7 fall ignored clr", xflag_o, 4'b0000);
    xint_pin[1] = 1'b0; cyc(5);
    chk("R6 fall sets", xflag_o, 4'b0010);
    chk("R2 xint1 vec", {irq_o, vec_o}, {1'b1, 8'h4B});
    // R7 acknowledge clears the winner flag
    pulse_ack();
    chk("R7 ack clears", xflag_o, 4'b0000);
    chk("R9 push lo", {svc_hi_o, svc_lo_o}, 2'b01);
    pulse_ret();
    chk("R9 pop lo", {svc_hi_o, svc_lo_o}, 2'b00);
    xint_pin[1] = 1'b1; xint_pin[3] = 1'b0; xint_pin[2] = 1'b1; cyc(5);
    chk("R6 pins 2 3", xflag_o, 4'b1100);
    chk("R3 order xint2", vec_o, 8'h53);
    ext_pri = 4'b1000; cyc(2);
    chk("R3 level xint3", {irq_hi_o, vec_o}, {1'b1, 8'h5B});
    xint_pin[3] = 1'b1; xint_pin[2] = 1'b0; cyc(5);
    quiet();
    chk("R6 reverse ignored", xflag_o, 4'b0000);
    ext_pri = 0;

    // R8 R9 nesting
    cls_en = 6'h0F; cls_pri = 6'b001100; tmr0_req = 1'b1; cyc(2);
    pulse_ack();
    chk("R11 after ack", irq_o, 0);
    tmr0_req = 1'b0; ext0_req = 1'b1; cyc(2);
    chk("R8 lo blocks lo", irq_o, 0);
    ext1_req = 1'b1; cyc(2);
    chk("R8 hi preempts lo", {irq_o, irq_hi_o, vec_o}, {2'b11, 8'h13});
    pulse_ack();
    chk("R9 both", {svc_hi_o, svc_lo_o}, 2'b11);
    ext1_req = 1'b0; tmr1_req = 1'b1; cyc(2);
    chk("R8 hi blocks hi", irq_o, 0);
    pulse_ret(); cyc(1);
    chk("R9 pop hi first", {svc_hi_o, svc_lo_o}, 2'b01);
    chk("R8 hi after pop", {irq_o, vec_o}, {1'b1, 8'h1B});
    pulse_ack(); tmr1_req = 1'b0;
    pulse_ret(); pulse_ret(); cyc(1);
    chk("R9 empty", {svc_hi_o, svc_lo_o}, 2'b00);
    chk("R8 lo resumes", {irq_o, vec_o}, {1'b1, 8'h03});
    quiet();

    // R10 wake without a clock edge
    ext_en = 4'b0100;
    @(posedge clk); #1 xint_pin[2] = 1'b1;
    #1 chk("R10 wake async", wake_o, 1);
    cyc(5);
    chk("R10 wake settles", wake_o, 0);
    ext_en = 4'b0000;
    xint_pin[0] = 1'b1; #1 chk("R10 disabled no wake", wake_o, 0);
    cyc(5);
    quiet();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule